// File: doc/BRIEF.md
# Tag-Vector Hit Detection for a Translation-Coupled Instruction Cache

This block decides whether an instruction fetch hits in a four-way set-associative, virtually indexed instruction cache, and which way holds the line. The cache is bound tightly to a small fully associative translation buffer. A cache tag does not hold a physical address. It holds a one-hot vector that points at the translation-buffer entry covering the line's page. On a lookup, the virtual page number is compared against every translation entry to form a match vector. Each way of the indexed set then hits when its stored vector shares a set bit with that match vector. No translated address takes part in the hit decision.

The set index and the half-line select both come from page-offset bits, so indexing can start before translation finishes. The response is registered one cycle after the lookup. It carries the hit flag, the way, a translation-miss flag and one 32-byte half of the 64-byte line. A fill writes a line into a set. Its tag becomes the one-hot code of the translation entry that currently matches the fill address, and the victim way comes from a round-robin pointer kept for each set. When a translation entry is rewritten, every tag bit that points at that entry is cleared in the same edge, so no line can outlive its translation. The translation buffer must never hold the same page number in two valid entries.

Top module: `pvt_icache_hit`

## Requirements
- R1: After reset `rsp_valid` is 0, all translation entries are invalid and all tags are empty, so the first lookup reports `rsp_tlb_miss`=1 and `rsp_hit`=0.
- R2: `rsp_valid` is 1 exactly in the cycle after a cycle with `lk_valid`=1. When `rsp_valid` is 0, `rsp_hit` and `rsp_tlb_miss` are 0.
- R3: A lookup whose page number (address bits [31:12]) matches no valid translation entry responds with `rsp_tlb_miss`=1, `rsp_hit`=0 and `rsp_data`=0.
- R4: A lookup whose page matches a translation entry, but where no way of the set (address bits [11:6]) carries that entry's bit, responds with `rsp_hit`=0, `rsp_tlb_miss`=0 and `rsp_data`=0.
- R5: On a hit, `rsp_way` names the hitting way. `rsp_data` is line bytes 0..31 (line bits [255:0]) when address bit 5 is 0, and line bytes 32..63 (line bits [511:256]) when address bit 5 is 1.
- R6: A fill into a set where no way hits goes to the way named by that set's pointer. The pointer starts at way 0 after reset and steps 0,1,2,3,0 on each such fill. Each set has its own pointer.
- R7: A fill whose address already hits in its set rewrites the data of the hitting way and leaves the pointer unchanged.
- R8: A fill whose page matches no translation entry is dropped. It changes neither the lines nor the pointer.
- R9: Writing a translation entry clears that entry's bit from every tag, so every line tied to the entry misses afterwards, even when the same page number is written back.
- R10: When a translation write and a fill happen in the same cycle, the fill is dropped.
- R11: At most one way hits in any lookup.
- R12: A lookup in the same cycle as a fill or a translation write sees the state from before that clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | 32 | Lookup virtual address |
| fill_en | input | 1 | Fill request |
| fill_vaddr | input | 32 | Virtual address of the line being filled |
| fill_data | input | 512 | Full line contents for the fill |
| tlb_wr_en | input | 1 | Translation entry write |
| tlb_wr_idx | input | 5 | Entry being written |
| tlb_wr_vpn | input | 20 | Page number stored into the entry |
| rsp_valid | output | 1 | Response present (lookup one cycle earlier) |
| rsp_hit | output | 1 | A way hit |
| rsp_tlb_miss | output | 1 | No translation entry matched |
| rsp_way | output | 2 | Hitting way, 0 on a miss |
| rsp_data | output | 256 | Selected half line, 0 on a miss |

## Verification
A stale or misplaced tag bit shows up at the ports on the very next lookup of the affected set. It can appear as a hit that should have been invalidated, as a wrong `rsp_way`, or as data belonging to another line. A round-robin pointer that has slipped stays hidden until the next fill to that set, and then shows up one lookup later as a wrong way or as the eviction of the wrong line. For this reason every pointer and tag check pairs a fill with an immediate lookup, and each way of every set is read back in both halves.

// File: rtl/pvt_pkg.sv
// Package: default geometry shared by the tag-vector cache modules.
// Assumes power-of-two sizes and a set index plus line offset that fit in the page offset.
package pvt_pkg;
    localparam int VA_W_D        = 32;
    localparam int PAGE_BITS_D   = 12;
    localparam int TLB_N_D       = 32;
    localparam int WAYS_D        = 4;
    localparam int SETS_D        = 64;
    localparam int LINE_BYTES_D  = 64;
    localparam int READ_BYTES_D  = 32;
endpackage

// File: rtl/pvt_tlb.sv
// Module: fully associative translation store with two match ports.
// Produces one match line per valid entry whose page number equals the query.
// Assumes software never holds one page number in two valid entries.
module pvt_tlb #(
    parameter int TLB_N = 32,
    parameter int VPN_W = 20,
    localparam int IDX_W = $clog2(TLB_N)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [VPN_W-1:0] wr_vpn,
    input  logic [VPN_W-1:0] q_vpn_a,
    input  logic [VPN_W-1:0] q_vpn_b,
    output logic [TLB_N-1:0] match_a,
    output logic [TLB_N-1:0] match_b
);
    logic [VPN_W-1:0] vpn_q [TLB_N];
    logic [TLB_N-1:0] vld_q;

    // Entry write: store page number and mark the entry valid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '0;
            for (int e = 0; e < TLB_N; e++) vpn_q[e] <= '0;
        end else if (wr_en) begin
            vld_q[wr_idx]  <= 1'b1;
            vpn_q[wr_idx]  <= wr_vpn;
        end
    end

    // Match lines: one comparator pair per entry.
    for (genvar e = 0; e < TLB_N; e++) begin : g_cmp
        assign match_a[e] = vld_q[e] && (vpn_q[e] == q_vpn_a);
        assign match_b[e] = vld_q[e] && (vpn_q[e] == q_vpn_b);
    end
endmodule

// File: rtl/pvt_tag_store.sv
// Module: one-hot translation tags per way plus a round-robin pointer per set.
// A column clear wipes one entry's bit from every tag; a write loads one tag.
// Assumes the caller never asks for a clear and a write in the same cycle.
module pvt_tag_store #(
    parameter int SETS  = 64,
    parameter int WAYS  = 4,
    parameter int TLB_N = 32,
    localparam int SET_W = $clog2(SETS),
    localparam int WAY_W = $clog2(WAYS),
    localparam int IDX_W = $clog2(TLB_N)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        clr_en,
    input  logic [IDX_W-1:0]            clr_idx,
    input  logic                        wr_en,
    input  logic [SET_W-1:0]            wr_set,
    input  logic [WAY_W-1:0]            wr_way,
    input  logic [TLB_N-1:0]            wr_tag,
    input  logic                        adv_en,
    input  logic [SET_W-1:0]            rd_set_a,
    input  logic [SET_W-1:0]            rd_set_b,
    output logic [WAYS-1:0][TLB_N-1:0]  tags_a,
    output logic [WAYS-1:0][TLB_N-1:0]  tags_b,
    output logic [WAY_W-1:0]            ptr_b
);
    logic [WAYS-1:0][TLB_N-1:0] tag_q [SETS];
    logic [WAY_W-1:0]           ptr_q [SETS];

    // Tag and pointer update: reset, column clear, line write, pointer step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                tag_q[s] <= '0;
                ptr_q[s] <= '0;
            end
        end else begin
            if (clr_en) begin
                for (int s = 0; s < SETS; s++)
                    for (int w = 0; w < WAYS; w++)
                        tag_q[s][w][clr_idx] <= 1'b0;
            end
            if (wr_en)  tag_q[wr_set][wr_way] <= wr_tag;
            if (adv_en) ptr_q[wr_set]         <= ptr_q[wr_set] + 1'b1;
        end
    end

    // Read ports for the lookup set and the fill set.
    assign tags_a = tag_q[rd_set_a];
    assign tags_b = tag_q[rd_set_b];
    assign ptr_b  = ptr_q[rd_set_b];
endmodule

// File: rtl/pvt_way_hit.sv
// Module: per-way hit from tag vector AND match vector, encoded to a way number.
// Assumes at most one way overlaps; the lowest is reported if not.
module pvt_way_hit #(
    parameter int WAYS  = 4,
    parameter int TLB_N = 32,
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic [WAYS-1:0][TLB_N-1:0] tags,
    input  logic [TLB_N-1:0]           match,
    output logic [WAYS-1:0]            hit_vec,
    output logic                       hit_any,
    output logic [WAY_W-1:0]           hit_way
);
    // One overlap test per way.
    for (genvar w = 0; w < WAYS; w++) begin : g_way
        assign hit_vec[w] = |(tags[w] & match);
    end

    assign hit_any = |hit_vec;

    // Encode the hitting way.
    always_comb begin
        hit_way = '0;
        for (int w = WAYS - 1; w >= 0; w--)
            if (hit_vec[w]) hit_way = WAY_W'(w);
    end
endmodule

// File: rtl/pvt_icache_hit.sv
// Module: top of the tag-vector instruction cache hit path.
// Lookup is answered one cycle later; fills pick the hitting way or the set pointer.
// A translation write takes priority over a fill in the same cycle.
module pvt_icache_hit
    import pvt_pkg::*;
#(
    parameter int VA_W       = VA_W_D,
    parameter int PAGE_BITS  = PAGE_BITS_D,
    parameter int TLB_N      = TLB_N_D,
    parameter int WAYS       = WAYS_D,
    parameter int SETS       = SETS_D,
    parameter int LINE_BYTES = LINE_BYTES_D,
    parameter int READ_BYTES = READ_BYTES_D,
    localparam int VPN_W  = VA_W - PAGE_BITS,
    localparam int IDX_W  = $clog2(TLB_N),
    localparam int WAY_W  = $clog2(WAYS),
    localparam int SET_W  = $clog2(SETS),
    localparam int OFF_W  = $clog2(LINE_BYTES),
    localparam int RB_W   = $clog2(READ_BYTES),
    localparam int HALF_W = OFF_W - RB_W,
    localparam int LINE_W = LINE_BYTES * 8,
    localparam int READ_W = READ_BYTES * 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_valid,
    input  logic [VA_W-1:0]   lk_vaddr,
    input  logic              fill_en,
    input  logic [VA_W-1:0]   fill_vaddr,
    input  logic [LINE_W-1:0] fill_data,
    input  logic              tlb_wr_en,
    input  logic [IDX_W-1:0]  tlb_wr_idx,
    input  logic [VPN_W-1:0]  tlb_wr_vpn,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic              rsp_tlb_miss,
    output logic [WAY_W-1:0]  rsp_way,
    output logic [READ_W-1:0] rsp_data
);
    logic [SET_W-1:0]           lk_set, fl_set;
    logic [HALF_W-1:0]          lk_half;
    logic [TLB_N-1:0]           lk_match, fl_match;
    logic [WAYS-1:0][TLB_N-1:0] lk_tags, fl_tags;
    logic [WAY_W-1:0]           fl_ptr;
    logic [WAYS-1:0]            lk_hit_vec, fl_hit_vec;
    logic                       lk_hit_any, fl_hit_any;
    logic [WAY_W-1:0]           lk_hit_way, fl_hit_way;
    logic                       fill_go;
    logic [WAY_W-1:0]           fill_way;
    logic [LINE_W-1:0]          line_rd;
    logic [LINE_W-1:0]          data_mem [SETS*WAYS];

    assign lk_set  = lk_vaddr[OFF_W +: SET_W];
    assign fl_set  = fill_vaddr[OFF_W +: SET_W];
    assign lk_half = lk_vaddr[RB_W +: HALF_W];

    pvt_tlb #(.TLB_N(TLB_N), .VPN_W(VPN_W)) tlb_i (
        .clk(clk), .rst_n(rst_n),
        .wr_en(tlb_wr_en), .wr_idx(tlb_wr_idx), .wr_vpn(tlb_wr_vpn),
        .q_vpn_a(lk_vaddr[VA_W-1:PAGE_BITS]), .q_vpn_b(fill_vaddr[VA_W-1:PAGE_BITS]),
        .match_a(lk_match), .match_b(fl_match)
    );

    pvt_tag_store #(.SETS(SETS), .WAYS(WAYS), .TLB_N(TLB_N)) tags_i (
        .clk(clk), .rst_n(rst_n),
        .clr_en(tlb_wr_en), .clr_idx(tlb_wr_idx),
        .wr_en(fill_go), .wr_set(fl_set), .wr_way(fill_way), .wr_tag(fl_match),
        .adv_en(fill_go && !fl_hit_any),
        .rd_set_a(lk_set), .rd_set_b(fl_set),
        .tags_a(lk_tags), .tags_b(fl_tags), .ptr_b(fl_ptr)
    );

    pvt_way_hit #(.WAYS(WAYS), .TLB_N(TLB_N)) lk_hit_i (
        .tags(lk_tags), .match(lk_match),
        .hit_vec(lk_hit_vec), .hit_any(lk_hit_any), .hit_way(lk_hit_way)
    );

    pvt_way_hit #(.WAYS(WAYS), .TLB_N(TLB_N)) fl_hit_i (
        .tags(fl_tags), .match(fl_match),
        .hit_vec(fl_hit_vec), .hit_any(fl_hit_any), .hit_way(fl_hit_way)
    );

    // Fill decision: needs a translation and no concurrent translation write.
    assign fill_go  = fill_en && !tlb_wr_en && (|fl_match);
    assign fill_way = fl_hit_any ? fl_hit_way : fl_ptr;

    // Data array write on an accepted fill.
    always_ff @(posedge clk) begin
        if (fill_go) data_mem[{fl_set, fill_way}] <= fill_data;
    end

    assign line_rd = data_mem[{lk_set, lk_hit_way}];

    // Response register: hit, way, translation miss and selected half line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid    <= 1'b0;
            rsp_hit      <= 1'b0;
            rsp_tlb_miss <= 1'b0;
            rsp_way      <= '0;
            rsp_data     <= '0;
        end else begin
            rsp_valid    <= lk_valid;
            rsp_hit      <= lk_valid && lk_hit_any;
            rsp_tlb_miss <= lk_valid && !(|lk_match);
            rsp_way      <= (lk_valid && lk_hit_any) ? lk_hit_way : '0;
            rsp_data     <= (lk_valid && lk_hit_any) ? line_rd[lk_half*READ_W +: READ_W] : '0;
        end
    end
endmodule

// File: rtl/pvt_icache_hit_chk.sv
// Module: property checker bound to the cache hit path top.
// Watches the response timing, miss encoding and the single-hit rule.
module pvt_icache_hit_chk #(
    parameter int WAYS   = 4,
    parameter int READ_W = 256
) (
    input logic              clk,
    input logic              rst_n,
    input logic              lk_valid,
    input logic              rsp_valid,
    input logic              rsp_hit,
    input logic              rsp_tlb_miss,
    input logic [READ_W-1:0] rsp_data,
    input logic [WAYS-1:0]   lk_hit_vec
);
    // R2
    rsp_follows_lookup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> rsp_valid);
    // R2
    rsp_idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> (!rsp_hit && !rsp_tlb_miss));
    // R3
    tlb_miss_no_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_tlb_miss |-> !rsp_hit);
    // R4
    miss_data_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_hit |-> (rsp_data == '0));
    // R11
    single_way_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |-> $onehot0(lk_hit_vec));
endmodule

bind pvt_icache_hit pvt_icache_hit_chk #(.WAYS(WAYS), .READ_W(READ_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .rsp_valid(rsp_valid),
    .rsp_hit(rsp_hit), .rsp_tlb_miss(rsp_tlb_miss), .rsp_data(rsp_data),
    .lk_hit_vec(lk_hit_vec)
);

// File: tb/pvt_icache_hit_tb.sv
// Bench: sweeps every set and way with arithmetic expectations, then corner cases.
module pvt_icache_hit_tb_top;
    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         lk_valid = 1'b0;
    logic [31:0]  lk_vaddr = '0;
    logic         fill_en = 1'b0;
    logic [31:0]  fill_vaddr = '0;
    logic [511:0] fill_data = '0;
    logic         tlb_wr_en = 1'b0;
    logic [4:0]   tlb_wr_idx = '0;
    logic [19:0]  tlb_wr_vpn = '0;
    logic         rsp_valid, rsp_hit, rsp_tlb_miss;
    logic [1:0]   rsp_way;
    logic [255:0] rsp_data;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pvt_icache_hit dut_i (
        .clk(clk), .rst_n(rst_n),
        .lk_valid(lk_valid), .lk_vaddr(lk_vaddr),
        .fill_en(fill_en), .fill_vaddr(fill_vaddr), .fill_data(fill_data),
        .tlb_wr_en(tlb_wr_en), .tlb_wr_idx(tlb_wr_idx), .tlb_wr_vpn(tlb_wr_vpn),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_tlb_miss(rsp_tlb_miss),
        .rsp_way(rsp_way), .rsp_data(rsp_data)
    );

    function automatic logic [19:0] vpn_of(input int e);
        return 20'h100 + 20'(e);
    endfunction

    function automatic logic [31:0] mkva(input logic [19:0] vpn, input int set, input bit half);
        return {vpn, 6'(set), half, 5'b0};
    endfunction

    function automatic logic [511:0] mk_line(input logic [31:0] va, input logic [7:0] tag);
        logic [511:0] l;
        for (int i = 0; i < 16; i++) l[i*32 +: 32] = {tag, 24'(va[31:6]) ^ 24'(i * 4099)};
        return l;
    endfunction

    // One cycle of stimulus; outputs of that cycle's lookup are ready on return.
    task automatic cyc(input bit lk, input logic [31:0] lva,
                       input bit fe, input logic [31:0] fva, input logic [511:0] fd,
                       input bit te, input logic [4:0] ti, input logic [19:0] tv);
        @(negedge clk);
        lk_valid = lk; lk_vaddr = lva;
        fill_en = fe; fill_vaddr = fva; fill_data = fd;
        tlb_wr_en = te; tlb_wr_idx = ti; tlb_wr_vpn = tv;
        @(negedge clk);
        lk_valid = 1'b0; fill_en = 1'b0; tlb_wr_en = 1'b0;
    endtask

    task automatic do_tlb(input int idx, input logic [19:0] v);
        cyc(0, '0, 0, '0, '0, 1, 5'(idx), v);
    endtask

    task automatic do_fill(input logic [31:0] va, input logic [7:0] tag);
        cyc(0, '0, 1, va, mk_line(va, tag), 0, '0, '0);
    endtask

    // Compare the response currently on the outputs with the expectation.
    task automatic cmp(input string req, input logic [31:0] va, input bit eh,
                       input bit etm, input int ew, input logic [511:0] line);
        logic [255:0] ed;
        int           ewy;
        ed  = eh ? (va[5] ? line[511:256] : line[255:0]) : '0;
        ewy = eh ? ew : 0;
        n_chk++;
        if (rsp_valid !== 1'b1 || rsp_hit !== eh || rsp_tlb_miss !== etm ||
            rsp_way !== 2'(ewy) || rsp_data !== ed) begin
            n_bad++;
            $display("FAIL %s va=%h: act v=%b hit=%b tm=%b way=%0d data=%h / exp v=1 hit=%b tm=%b way=%0d data=%h",
                     req, va, rsp_valid, rsp_hit, rsp_tlb_miss, rsp_way, rsp_data,
                     eh, etm, ewy, ed);
        end
    endtask

    task automatic look_chk(input string req, input logic [31:0] va, input bit eh,
                            input bit etm, input int ew, input logic [511:0] line);
        cyc(1, va, 0, '0, '0, 0, '0, '0);
        cmp(req, va, eh, etm, ew, line);
    endtask

    task automatic flag_chk(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: act=%b exp=%b", req, act, exp);
        end
    endtask

    initial begin
        logic [31:0] va;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        flag_chk("R1 rsp_valid after reset", rsp_valid, 1'b0);
        look_chk("R1 R3 first lookup", mkva(vpn_of(0), 0, 0), 0, 1, 0, '0);

        for (int e = 0; e < 32; e++) do_tlb(e, vpn_of(e));
        // R3: unmapped page
        look_chk("R3 unmapped page", mkva(20'h77777, 9, 1), 0, 1, 0, '0);

        // Sweep every set: R4 before fills, R6 placement, R5 both halves, R11
        for (int s = 0; s < 64; s++) begin
            look_chk("R4 empty set", mkva(vpn_of(s % 32), s, 0), 0, 0, 0, '0);
            for (int k = 0; k < 4; k++) do_fill(mkva(vpn_of((s + k) % 32), s, 0), 8'(k));
            for (int k = 0; k < 4; k++)
                for (int h = 0; h < 2; h++) begin
                    va = mkva(vpn_of((s + k) % 32), s, h[0]);
                    look_chk("R5 R6 R11 sweep", va, 1, 0, k, mk_line(va, 8'(k)));
                end
        end

        // R6: fifth fill wraps to way 0 and evicts the first line
        va = mkva(vpn_of(4), 0, 0);
        do_fill(va, 8'h40);
        look_chk("R6 wrap", va, 1, 0, 0, mk_line(va, 8'h40));
        look_chk("R6 evicted", mkva(vpn_of(0), 0, 0), 0, 0, 0, '0);

        // R7: refill of a present line rewrites its way, pointer stays
        va = mkva(vpn_of(3), 1, 1);
        do_fill(va, 8'h50);
        look_chk("R7 rewrite", va, 1, 0, 2, mk_line(va, 8'h50));
        va = mkva(vpn_of(10), 1, 0);
        do_fill(va, 8'h51);
        look_chk("R7 pointer kept", va, 1, 0, 0, mk_line(va, 8'h51));
        look_chk("R7 way0 evicted", mkva(vpn_of(1), 1, 0), 0, 0, 0, '0);

        // R8: fill without translation is dropped
        va = mkva(20'hFFFFF, 2, 0);
        do_fill(va, 8'h60);
        look_chk("R8 dropped fill", va, 0, 1, 0, '0);
        va = mkva(vpn_of(20), 2, 0);
        do_fill(va, 8'h61);
        look_chk("R8 pointer kept", va, 1, 0, 0, mk_line(va, 8'h61));

        // R9: rewriting an entry, even with the same page, drops its lines
        do_tlb(5, vpn_of(5));
        look_chk("R9 set5 cleared", mkva(vpn_of(5), 5, 0), 0, 0, 0, '0);
        look_chk("R9 set4 cleared", mkva(vpn_of(5), 4, 1), 0, 0, 0, '0);
        va = mkva(vpn_of(6), 6, 0);
        look_chk("R9 neighbour kept", va, 1, 0, 0, mk_line(va, 8'h00));

        // R10: translation write wins over a fill in the same cycle
        va = mkva(vpn_of(31), 10, 0);
        cyc(0, '0, 1, va, mk_line(va, 8'h70), 1, 5'd30, 20'h00500);
        look_chk("R10 fill dropped", va, 0, 0, 0, '0);
        look_chk("R10 R9 entry30 lines gone", mkva(20'h00500, 30, 0), 0, 0, 0, '0);
        do_fill(va, 8'h71);
        look_chk("R10 pointer kept", va, 1, 0, 0, mk_line(va, 8'h71));

        // R12: lookup alongside a fill sees the old state
        va = mkva(vpn_of(25), 11, 1);
        cyc(1, va, 1, va, mk_line(va, 8'h80), 0, '0, '0);
        cmp("R12 same-cycle lookup", va, 0, 0, 0, '0);
        look_chk("R12 after fill", va, 1, 0, 0, mk_line(va, 8'h80));

        // R2: idle cycle gives no response
        cyc(0, '0, 0, '0, '0, 0, '0, '0);
        flag_chk("R2 idle rsp_valid", rsp_valid, 1'b0);
        flag_chk("R2 idle rsp_hit", rsp_hit, 1'b0);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    // Watchdog: a hung run is counted as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: act=timeout exp=completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule